// File: doc/BRIEF.md
# Crosstalk-Avoiding Cluster Bus-Invert Encoder

This block encodes a data word for a long on-chip bus so that adjacent wires rarely switch against each other. The word is cut into clusters of four data bits. Each cluster gets one extra wire that says whether its data travels inverted. An n-bit word therefore needs n + n/4 wires. For every cluster the encoder compares two candidates with the word already on the bus. The first candidate is the plain data with its invert wire low. The second is the complemented data with its invert wire high. It then picks the candidate that avoids the severe coupling patterns on every group of three neighbouring wires.

A parameter sets how strict the encoder is. The basic mode rejects coupling weights 3 and 4. The extended mode also rejects weight 2. The chosen word is held in an output register, and that register is also the previous bus state for the next decision. Words enter and leave through a valid/ready handshake with one register stage.

Top module: `xt_bus_encoder`

## Requirements
- R1: With DATA_W a multiple of 4 and N = DATA_W/4 clusters, out_bus is DATA_W+N wires wide. Cluster k uses wires 5k..5k+4. Data bit 4k+j sits on wire 5k+j, and the cluster's invert wire is wire 5k+4.
- R2: In every transmitted word, the four data wires of cluster k equal in_data[4k+3:4k] XOR-ed with that cluster's invert wire.
- R3: Each wire's change against the registered bus word counts as rising, falling or quiet. The weight of a three-wire group is the sum, over its two neighbours, of 0 when the centre and that neighbour change identically, 1 when exactly one of them switches, and 2 when they switch in opposite directions.
- R4: A group is forbidden when its weight is at least 3 with MODE = XT_AVOID_T43 (encoding 0), or at least 2 with MODE = XT_AVOID_T432 (encoding 1).
- R5: Cluster k always judges the groups centred on its local wires 1, 2 and 3. For k > 0 it also judges the group centred on local wire 0. There, the left neighbour is the registered invert wire of cluster k-1, and it is assumed not to switch. For k < N-1 it also judges the group centred on its invert wire. There, the right neighbour's new level is taken as in_data[4k+4] XOR the registered invert wire of cluster k+1.
- R6: A cluster whose plain candidate has no forbidden group is sent plain, with its invert wire at 0.
- R7: A cluster whose plain candidate has a forbidden group but whose inverted candidate has none is sent inverted, with its invert wire at 1.
- R8: When both candidates have a forbidden group, the one with the lower sum of judged group weights is sent. On equal sums the plain candidate is sent.
- R9: A synchronous active-low reset sets out_bus to all zeros and out_valid to 0.
- R10: in_ready is high whenever out_valid is low or out_ready is high. A word accepted at a rising edge is on out_bus with out_valid high right after that edge. While out_valid is high and out_ready is low, out_bus and out_valid hold.
- R11: out_bus, and with it the previous-state reference, changes only at an edge where a word is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | A data word is offered |
| in_ready | output | 1 | The encoder can take the offered word |
| in_data | input | DATA_W | Raw data word |
| out_valid | output | 1 | out_bus holds a word not yet taken |
| out_ready | input | 1 | The receiver takes the word on out_bus |
| out_bus | output | DATA_W+DATA_W/4 | Encoded wires: four data wires plus one invert wire per cluster |

## Verification
The encoded word and out_valid are due one rising edge after acceptance. in_ready is combinational and is due in the same cycle as out_ready changes. The bench drives every input on a falling edge and checks in_ready one nanosecond later. It checks out_bus and out_valid on the next falling edge, after exactly one register. For each width and mode it keeps its own copy of the previous bus word and advances it only when it has counted a word as accepted, so a stalled word is expected to hold. Its expected word comes from a weight model built from R3 to R8.

// File: rtl/xt_enc_pkg.sv
// Shared constants, mode type and coupling-weight helpers for the
// cluster bus-invert encoder. Assumes wires are compared against the
// registered bus word of the previous transfer.
package xt_enc_pkg;

    localparam int CL_DATA  = 4;            // data bits per cluster
    localparam int CL_WIRES = CL_DATA + 1;  // data wires plus invert wire
    localparam int GRP_CNT  = CL_WIRES;     // groups a cluster may judge
    localparam int GRP_W    = 3;            // weight of one group: 0..4
    localparam int SUM_W    = $clog2(GRP_CNT * 4 + 1);

    // Strictness of the avoidance rule.
    typedef enum logic {
        XT_AVOID_T43  = 1'b0,   // reject weight 3 and 4
        XT_AVOID_T432 = 1'b1    // reject weight 2, 3 and 4
    } xt_mode_e;

    // Coupling seen between a centre wire and one neighbour.
    function automatic logic [1:0] pair_cost(input logic c_old, input logic c_new,
                                             input logic s_old, input logic s_new);
        logic tc;
        logic ts;
        tc = c_old ^ c_new;
        ts = s_old ^ s_new;
        if (tc && ts)
            return (c_new == s_new) ? 2'd0 : 2'd2;
        else if (tc || ts)
            return 2'd1;
        else
            return 2'd0;
    endfunction

    // Lowest group weight that counts as forbidden in a mode.
    function automatic logic [GRP_W-1:0] limit_of(input xt_mode_e m);
        return (m == XT_AVOID_T432) ? 3'd2 : 3'd3;
    endfunction

endpackage

// File: rtl/xt_group_cost.sv
// Weight of one three-wire group: the coupling the centre wire (index 1)
// sees from both neighbours between the old and new levels. Purely
// combinational; assumes bit 1 of each vector is the centre wire.
module xt_group_cost
    import xt_enc_pkg::*;
(
    input  logic [2:0]       prv,
    input  logic [2:0]       nxt,
    output logic [GRP_W-1:0] cost
);

    logic [1:0] left_c;
    logic [1:0] right_c;

    // Weight against each neighbour, then the total.
    assign left_c  = pair_cost(prv[1], nxt[1], prv[0], nxt[0]);
    assign right_c = pair_cost(prv[1], nxt[1], prv[2], nxt[2]);
    assign cost    = {1'b0, left_c} + {1'b0, right_c};

endmodule

// File: rtl/xt_cluster_judge.sv
// Invert decision for one four-bit cluster. Builds the plain and the
// inverted candidate, weighs every judged three-wire group against the
// registered bus, and selects per the avoidance and tie rules.
// Assumes: neighbour levels outside the cluster are estimates supplied
// by the parent (left neighbour unchanged, right neighbour from its
// registered invert wire).
module xt_cluster_judge
    import xt_enc_pkg::*;
#(
    parameter xt_mode_e MODE      = XT_AVOID_T432,
    parameter bit       HAS_LEFT  = 1'b1,
    parameter bit       HAS_RIGHT = 1'b1
) (
    input  logic [CL_DATA-1:0]  data,
    input  logic [CL_WIRES-1:0] prev_w,
    input  logic                left_prev,
    input  logic                right_prev,
    input  logic                right_next,
    output logic                inv_sel,
    output logic                true_bad,
    output logic                inv_bad
);

    localparam int               EXT_W = CL_WIRES + 2;
    localparam logic [GRP_W-1:0] LIMIT = limit_of(MODE);

    logic [EXT_W-1:0] old_ext;
    logic [EXT_W-1:0] new_ext  [2];
    logic [GRP_W-1:0] cost     [2][GRP_CNT];
    logic [GRP_W-1:0] cost_en  [2][GRP_CNT];
    logic [GRP_CNT-1:0] grp_bad [2];
    logic [SUM_W-1:0] sum      [2];

    // Extended vectors: index 0 left neighbour, 1..5 own wires, 6 right.
    assign old_ext    = {right_prev, prev_w, left_prev};
    assign new_ext[0] = {right_next, 1'b0, data, left_prev};
    assign new_ext[1] = {right_next, 1'b1, ~data, left_prev};

    for (genvar c = 0; c < 2; c++) begin : g_cand
        for (genvar g = 0; g < GRP_CNT; g++) begin : g_grp
            localparam bit EN = (g == 0) ? HAS_LEFT :
                                ((g == GRP_CNT - 1) ? HAS_RIGHT : 1'b1);

            xt_group_cost u_cost (
                .prv  (old_ext[g +: 3]),
                .nxt  (new_ext[c][g +: 3]),
                .cost (cost[c][g])
            );

            // Mask groups that this cluster does not judge.
            assign cost_en[c][g] = EN ? cost[c][g] : '0;
            assign grp_bad[c][g] = EN && (cost[c][g] >= LIMIT);
        end
    end

    // Total judged weight of each candidate.
    always_comb begin
        for (int c = 0; c < 2; c++) begin
            sum[c] = '0;
            for (int g = 0; g < GRP_CNT; g++)
                sum[c] = sum[c] + SUM_W'(cost_en[c][g]);
        end
    end

    assign true_bad = |grp_bad[0];
    assign inv_bad  = |grp_bad[1];

    // Selection line for the 2-to-1 data/complement multiplexer.
    always_comb begin
        if (!true_bad)
            inv_sel = 1'b0;
        else if (!inv_bad)
            inv_sel = 1'b1;
        else
            inv_sel = (sum[1] < sum[0]);
    end

endmodule

// File: rtl/xt_out_stage.sv
// Single register stage with valid/ready flow control. Holds the bus
// word, which also serves as the previous-state reference. Assumes the
// word on word_d is only meaningful while in_valid is high.
module xt_out_stage #(
    parameter int BUS_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [BUS_W-1:0] word_d,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [BUS_W-1:0] bus_q
);

    logic fire;

    // Accept when empty or when the held word is being taken.
    assign in_ready = !out_valid || out_ready;
    assign fire     = in_valid && in_ready;

    // Bus word register, updated only on accepted transfers.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bus_q <= '0;
        else if (fire)
            bus_q <= word_d;
    end

    // Output valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n)
            out_valid <= 1'b0;
        else if (fire)
            out_valid <= 1'b1;
        else if (out_ready)
            out_valid <= 1'b0;
    end

endmodule

// File: rtl/xt_bus_encoder.sv
// Top of the cluster bus-invert encoder. Splits in_data into four-bit
// clusters, lets each cluster judge plain versus inverted transmission
// against the registered bus, multiplexes the result and registers it.
// Assumes DATA_W is a non-zero multiple of 4.
module xt_bus_encoder
    import xt_enc_pkg::*;
#(
    parameter int       DATA_W = 32,
    parameter xt_mode_e MODE   = XT_AVOID_T432,
    localparam int      N_CL   = DATA_W / CL_DATA,
    localparam int      BUS_W  = DATA_W + N_CL
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [BUS_W-1:0]  out_bus
);

    logic [BUS_W-1:0] bus_q;
    logic [BUS_W-1:0] word_d;
    logic [N_CL-1:0]  inv_w;
    logic [N_CL-1:0]  true_bad_w;
    logic [N_CL-1:0]  inv_bad_w;

    for (genvar k = 0; k < N_CL; k++) begin : g_cl
        logic lp;
        logic rp;
        logic rn;

        // Left neighbour: previous cluster's registered invert wire.
        if (k > 0) begin : g_left
            assign lp = bus_q[CL_WIRES*k - 1];
        end else begin : g_noleft
            assign lp = 1'b0;
        end

        // Right neighbour: next cluster's first wire, estimated with its
        // registered invert decision.
        if (k < N_CL - 1) begin : g_right
            assign rp = bus_q[CL_WIRES*(k+1)];
            assign rn = in_data[CL_DATA*(k+1)] ^ bus_q[CL_WIRES*(k+1) + CL_DATA];
        end else begin : g_noright
            assign rp = 1'b0;
            assign rn = 1'b0;
        end

        xt_cluster_judge #(
            .MODE      (MODE),
            .HAS_LEFT  (k > 0),
            .HAS_RIGHT (k < N_CL - 1)
        ) u_judge (
            .data       (in_data[CL_DATA*k +: CL_DATA]),
            .prev_w     (bus_q[CL_WIRES*k +: CL_WIRES]),
            .left_prev  (lp),
            .right_prev (rp),
            .right_next (rn),
            .inv_sel    (inv_w[k]),
            .true_bad   (true_bad_w[k]),
            .inv_bad    (inv_bad_w[k])
        );

        // Data/complement multiplexer plus invert wire.
        assign word_d[CL_WIRES*k +: CL_WIRES] =
            {inv_w[k], in_data[CL_DATA*k +: CL_DATA] ^ {CL_DATA{inv_w[k]}}};
    end

    xt_out_stage #(
        .BUS_W (BUS_W)
    ) u_stage (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .word_d    (word_d),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .bus_q     (bus_q)
    );

    assign out_bus = bus_q;

endmodule

// File: rtl/xt_bus_encoder_chk.sv
// Property checker for the cluster bus-invert encoder, bound to the top.
module xt_bus_encoder_chk #(
    parameter int  DATA_W = 32,
    localparam int N_CL   = DATA_W / 4,
    localparam int BUS_W  = DATA_W + N_CL
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic [DATA_W-1:0] in_data,
    input logic              out_valid,
    input logic              out_ready,
    input logic [BUS_W-1:0]  out_bus,
    input logic [N_CL-1:0]   true_bad,
    input logic [N_CL-1:0]   inv_bad
);

    logic fire;
    assign fire = in_valid && in_ready;

    AST_FIRE_SETS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> out_valid);  // R10

    AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_bus)));  // R10

    AST_IDLE_KEEPS_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        !fire |=> $stable(out_bus));  // R11

    for (genvar k = 0; k < N_CL; k++) begin : g_cl
        AST_DATA_FOLLOWS_INV: assert property (@(posedge clk) disable iff (!rst_n)
            fire |=> (out_bus[5*k +: 4] ==
                      ($past(in_data[4*k +: 4]) ^ {4{out_bus[5*k+4]}})));  // R2

        AST_PLAIN_WHEN_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
            (fire && !true_bad[k]) |=> !out_bus[5*k+4]);  // R6

        AST_INVERT_RESCUES: assert property (@(posedge clk) disable iff (!rst_n)
            (fire && true_bad[k] && !inv_bad[k]) |=> out_bus[5*k+4]);  // R7
    end

endmodule

bind xt_bus_encoder xt_bus_encoder_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_bus   (out_bus),
    .true_bad  (true_bad_w),
    .inv_bad   (inv_bad_w)
);

// File: tb/xt_bus_encoder_tb_top.sv
// Directed bench for the cluster bus-invert encoder: five instances of
// different widths and modes share one input stream.
module xt_bus_encoder_tb_top;
    import xt_enc_pkg::*;

    localparam int NI = 5;
    localparam int WID [NI] = '{4, 4, 8, 16, 32};
    localparam bit T2M [NI] = '{1'b0, 1'b1, 1'b1, 1'b1, 1'b0};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        out_ready = 1'b1;
    logic [31:0] in_data = '0;

    logic [4:0]  o_w4a, o_w4b;
    logic [9:0]  o_w8;
    logic [19:0] o_w16;
    logic [39:0] o_w32;
    logic [NI-1:0] ov, ir;
    logic [39:0] obus [NI];

    int n_chk = 0;
    int n_fail = 0;
    logic [39:0] mprev [NI];
    bit          mov;

    always #4 clk = ~clk;

    xt_bus_encoder #(.DATA_W(4), .MODE(XT_AVOID_T43)) u_w4a (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(ir[0]),
        .in_data(in_data[3:0]), .out_valid(ov[0]), .out_ready(out_ready), .out_bus(o_w4a));
    xt_bus_encoder #(.DATA_W(4), .MODE(XT_AVOID_T432)) u_w4b (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(ir[1]),
        .in_data(in_data[3:0]), .out_valid(ov[1]), .out_ready(out_ready), .out_bus(o_w4b));
    xt_bus_encoder #(.DATA_W(8), .MODE(XT_AVOID_T432)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(ir[2]),
        .in_data(in_data[7:0]), .out_valid(ov[2]), .out_ready(out_ready), .out_bus(o_w8));
    xt_bus_encoder #(.DATA_W(16), .MODE(XT_AVOID_T432)) u_w16 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(ir[3]),
        .in_data(in_data[15:0]), .out_valid(ov[3]), .out_ready(out_ready), .out_bus(o_w16));
    xt_bus_encoder #(.DATA_W(32), .MODE(XT_AVOID_T43)) u_w32 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(ir[4]),
        .in_data(in_data), .out_valid(ov[4]), .out_ready(out_ready), .out_bus(o_w32));

    assign obus[0] = {35'b0, o_w4a};
    assign obus[1] = {35'b0, o_w4b};
    assign obus[2] = {30'b0, o_w8};
    assign obus[3] = {20'b0, o_w16};
    assign obus[4] = o_w32;

    task automatic chk(input bit ok, input string req, input logic [39:0] act,
                       input logic [39:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Neighbour coupling weight (R3).
    function automatic int pc(input logic co, input logic cn, input logic so, input logic sn);
        if ((co != cn) && (so != sn)) return (cn == sn) ? 0 : 2;
        if ((co != cn) || (so != sn)) return 1;
        return 0;
    endfunction

    // Expected encoded word from R1, R3..R8.
    function automatic logic [39:0] ref_enc(input int w, input bit t2,
                                            input logic [39:0] prv, input logic [31:0] d);
        logic [39:0] r;
        int nc;
        int lim;
        r = '0;
        nc = w / 4;
        lim = t2 ? 2 : 3;
        for (int k = 0; k < nc; k++) begin
            int  sum [2];
            bit  bad [2];
            bit  sel;
            for (int c = 0; c < 2; c++) begin
                logic [6:0] o;
                logic [6:0] n;
                o[0] = (k > 0) ? prv[(k > 0) ? 5*k-1 : 0] : 1'b0;
                n[0] = o[0];
                for (int j = 0; j < 5; j++) o[j+1] = prv[5*k+j];
                for (int j = 0; j < 4; j++) n[j+1] = d[4*k+j] ^ (c == 1);
                n[5] = (c == 1);
                o[6] = (k < nc-1) ? prv[(k < nc-1) ? 5*k+5 : 0] : 1'b0;
                n[6] = (k < nc-1) ? (d[(k < nc-1) ? 4*k+4 : 0] ^ prv[(k < nc-1) ? 5*k+9 : 0]) : 1'b0;
                sum[c] = 0;
                bad[c] = 1'b0;
                for (int g = 0; g < 5; g++) begin
                    int cost;
                    if (!((g == 0 && k == 0) || (g == 4 && k == nc-1))) begin
                        cost = pc(o[g+1], n[g+1], o[g], n[g]) + pc(o[g+1], n[g+1], o[g+2], n[g+2]);
                        sum[c] += cost;
                        if (cost >= lim) bad[c] = 1'b1;
                    end
                end
            end
            if (!bad[0]) sel = 1'b0;
            else if (!bad[1]) sel = 1'b1;
            else sel = (sum[1] < sum[0]);
            r[5*k +: 5] = {sel, d[4*k +: 4] ^ {4{sel}}};
        end
        return r;
    endfunction

    // Offer one word at a falling edge; update model on acceptance.
    task automatic drive(input bit v, input logic [31:0] d, input bit rdy);
        bit fire;
        in_valid = v;
        in_data = d;
        out_ready = rdy;
        #1;
        for (int i = 0; i < NI; i++)
            chk(ir[i] == (!mov || rdy), "R10 in_ready", 40'(ir[i]), 40'(!mov || rdy));
        fire = v && (!mov || rdy);
        if (fire) for (int i = 0; i < NI; i++) mprev[i] = ref_enc(WID[i], T2M[i], mprev[i], d);
        mov = fire ? 1'b1 : (rdy ? 1'b0 : mov);
        @(negedge clk);
    endtask

    task automatic check_model(input string req);
        for (int i = 0; i < NI; i++) begin
            chk(obus[i] == mprev[i], req, obus[i], mprev[i]);
            chk(ov[i] == mov, "R10 out_valid", 40'(ov[i]), 40'(mov));
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < NI; i++) mprev[i] = '0;
        mov = 1'b0;
        for (int i = 0; i < NI; i++) begin
            chk(obus[i] == '0, "R9 bus after reset", obus[i], '0);
            chk(ov[i] == 1'b0, "R9 valid after reset", 40'(ov[i]), 40'd0);
        end
    endtask

    // Hand-worked four-bit cases: quiet bus, then a Type-4 attempt.
    task automatic t_hand();
        drive(1'b1, 32'h0000_0005, 1'b1);
        chk(o_w4a == 5'b00101, "R6 plain word clean in basic mode", 40'(o_w4a), 40'h05);
        chk(o_w4b == 5'b00101, "R8 equal sums keep plain", 40'(o_w4b), 40'h05);
        check_model("R1 R5 model after 0x5");
        drive(1'b1, 32'h0000_000A, 1'b1);
        chk(o_w4a == 5'b10101, "R7 Type-4 avoided by inversion", 40'(o_w4a), 40'h15);
        chk(o_w4b == 5'b10101, "R4 R2 inverted word", 40'(o_w4b), 40'h15);
        check_model("R3 R5 model after 0xA");
        drive(1'b0, 32'h0, 1'b1);
        check_model("R10 valid drops when idle");
    endtask

    // Stalled output holds; new offer is refused until taken.
    task automatic t_stall();
        drive(1'b1, 32'h1234_5678, 1'b0);
        check_model("R10 accepted while empty");
        drive(1'b1, 32'hFEDC_BA98, 1'b0);
        check_model("R11 held under stall");
        drive(1'b1, 32'hFEDC_BA98, 1'b1);
        check_model("R10 accepted after release");
        drive(1'b0, 32'hAAAA_AAAA, 1'b1);
        check_model("R11 idle keeps bus");
    endtask

    // Walking and alternating patterns, then a random stream.
    task automatic t_patterns();
        for (int i = 0; i < 32; i++) begin
            drive(1'b1, 32'h1 << i, 1'b1);
            check_model("R5 walking one");
        end
        for (int i = 0; i < 16; i++) begin
            drive(1'b1, i[0] ? 32'h5555_5555 : 32'hAAAA_AAAA, 1'b1);
            check_model("R4 R7 alternating");
        end
        for (int i = 0; i < 600; i++) begin
            drive(($urandom % 4) != 0, $urandom, ($urandom % 3) != 0);
            check_model("R8 R2 random stream");
        end
    endtask

    initial begin
        #(8 * 150000);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        mov = 1'b0;
        @(negedge clk);
        t_reset();
        t_hand();
        t_stall();
        t_patterns();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule